// File: doc/BRIEF.md
# Issue Queue Wakeup with Scoreboard

This block holds dispatched instructions until their source operands are available, then hands them on with a class tag. Each instruction names up to two source physical registers and one destination physical register. A ready bit per physical register records whether its value has been produced. A completion broadcast of a destination tag marks that register ready and wakes every waiting source that names it.

Dispatch provides, for each source, the readiness that rename computed. The queue checks that readiness again against its own scoreboard and against a completion broadcast in the same cycle, so a value produced while the instruction was travelling to the queue is not missed. Tags at or above the physical register count (integer plus float) are not renamed, and the queue does not track them. A squash carrying a sequence number removes every younger entry that has not issued and sends it out through a drain port. Non-speculative instructions stay in their entries until a release names their sequence number. A full flag and a free-entry count give back-pressure to dispatch.

Top module: `iq_wakeup`

## Requirements
- R1: After reset the queue is empty (free count equals ENTRIES, full low, no issue, no drain) and every scoreboard bit reads not-ready.
- R2: Dispatching an instruction whose destination tag is below the physical register count clears that register's scoreboard bit.
- R3: A source dispatched as not-ready is taken as ready if the scoreboard bit for its tag is set, or if a completion broadcast of the same tag arrives in the dispatch cycle. Otherwise the entry waits.
- R4: A completion broadcast marks ready every waiting source whose tag matches and sets the scoreboard bit for that tag. A woken entry can issue in the cycle after the broadcast.
- R5: A tag at or above the physical register count is untracked. A source with such a tag counts as ready, and a destination with such a tag changes no scoreboard bit, including the bit whose number is the tag minus the register count.
- R6: The class is taken from the 4-bit kind field by priority: bit 3 (control) gives class 0 (branch), then bit 2 gives 1 (memory), then bit 1 gives 2 (integer), then bit 0 gives 3 (float), and no bit set gives 4 (misc).
- R7: At most one entry issues per cycle. It is the issuable entry with the smallest sequence number, and its entry is freed at that clock edge.
- R8: A squash invalidates only the occupied, unissued entries whose sequence number is greater than the squash number. Each one leaves through the drain port, one per cycle, and holds its entry until it has drained.
- R9: A non-speculative entry does not issue until a release with its exact sequence number arrives. A release that names another number has no effect.
- R10: The free count always equals ENTRIES minus the entries that are occupied and not yet issued or drained. Full is high when the count is zero, and a dispatch while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch an instruction this cycle |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_kind | input | 4 | {control, memory, integer, float} flags |
| disp_nonspec | input | 1 | Hold until a release with the same sequence number |
| disp_src0 | input | TAG_W | Source 0 physical tag |
| disp_src0_rdy | input | 1 | Source 0 ready at rename |
| disp_src1 | input | TAG_W | Source 1 physical tag |
| disp_src1_rdy | input | 1 | Source 1 ready at rename |
| disp_dst | input | TAG_W | Destination physical tag |
| wb_valid | input | 1 | Completion broadcast valid |
| wb_tag | input | TAG_W | Completed destination tag |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; entries with greater numbers are removed |
| rel_valid | input | 1 | Non-speculative release |
| rel_seq | input | SEQ_W | Sequence number being released |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_class | output | 3 | Class of the issuing entry (0..4) |
| iss_seq | output | SEQ_W | Sequence number of the issuing entry |
| drn_valid | output | 1 | A squashed entry drains this cycle |
| drn_seq | output | SEQ_W | Sequence number of the draining entry |
| free_cnt | output | CNT_W | Number of free entries |
| full | output | 1 | No free entry |

## Verification
The class mapping is swept over all sixteen kind values, which separates each step of the priority chain. The scoreboard sequence tells apart waiting on a broadcast, catching a register that became ready before arrival, catching a broadcast in the dispatch cycle, and having the bit cleared again by a new producer. An aliasing destination tag (a register number plus the register count) shows whether out-of-range tags leak into the scoreboard. Scrambled sequence numbers woken together expose the oldest-first order, and a squash in the middle of a waiting group, a mismatched release and a dispatch into a full queue each test one boundary of entry ownership.

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
  parameter int ENTRIES  = 8,
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int TAG_W    = 6,
  parameter int SEQ_W    = 16,
  parameter int IDX_W    = $clog2(ENTRIES),
  parameter int CNT_W    = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic [3:0]       disp_kind,
  input  logic             disp_nonspec,
  input  logic [TAG_W-1:0] disp_src0,
  input  logic             disp_src0_rdy,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic             disp_src1_rdy,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             rel_valid,
  input  logic [SEQ_W-1:0] rel_seq,
  output logic             iss_valid,
  output logic [2:0]       iss_class,
  output logic [SEQ_W-1:0] iss_seq,
  output logic             drn_valid,
  output logic [SEQ_W-1:0] drn_seq,
  output logic [CNT_W-1:0] free_cnt,
  output logic             full
);
  localparam int NREGS = INT_REGS + FP_REGS;
  localparam int SB_N  = 1 << TAG_W;
  localparam logic [2:0] CL_BR = 3'd0, CL_MEM = 3'd1, CL_INT = 3'd2,
                         CL_FP = 3'd3, CL_MISC = 3'd4;

  logic [ENTRIES-1:0] occ, sqd, hold, r0, r1;
  logic [TAG_W-1:0]   t0    [ENTRIES];
  logic [TAG_W-1:0]   t1    [ENTRIES];
  logic [SEQ_W-1:0]   seq_q [ENTRIES];
  logic [2:0]         cls_q [ENTRIES];
  logic [SB_N-1:0]    sb;
  logic [CNT_W-1:0]   free_q;

  logic wb_in, s0_in, s1_in, dst_in;
  assign wb_in  = 32'(wb_tag)    < NREGS;
  assign s0_in  = 32'(disp_src0) < NREGS;
  assign s1_in  = 32'(disp_src1) < NREGS;
  assign dst_in = 32'(disp_dst)  < NREGS;

  logic s0_ok, s1_ok;
  assign s0_ok = disp_src0_rdy || !s0_in || sb[disp_src0] ||
                 (wb_valid && wb_in && wb_tag == disp_src0);
  assign s1_ok = disp_src1_rdy || !s1_in || sb[disp_src1] ||
                 (wb_valid && wb_in && wb_tag == disp_src1);

  logic [2:0] disp_cls;
  always_comb begin
    if      (disp_kind[3]) disp_cls = CL_BR;
    else if (disp_kind[2]) disp_cls = CL_MEM;
    else if (disp_kind[1]) disp_cls = CL_INT;
    else if (disp_kind[0]) disp_cls = CL_FP;
    else                   disp_cls = CL_MISC;
  end

  logic             alloc_ok;
  logic [IDX_W-1:0] alloc_idx;
  always_comb begin
    alloc_ok  = 1'b0;
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        alloc_ok  = 1'b1;
        alloc_idx = IDX_W'(i);
      end
    end
  end

  logic [ENTRIES-1:0] issuable;
  assign issuable = occ & ~sqd & ~hold & r0 & r1;

  logic             iss_found;
  logic [IDX_W-1:0] iss_idx;
  logic [SEQ_W-1:0] best_seq;
  always_comb begin
    iss_found = 1'b0;
    iss_idx   = '0;
    best_seq  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (issuable[i] && (!iss_found || seq_q[i] < best_seq)) begin
        iss_found = 1'b1;
        iss_idx   = IDX_W'(i);
        best_seq  = seq_q[i];
      end
    end
  end

  logic             drn_found;
  logic [IDX_W-1:0] drn_idx;
  always_comb begin
    drn_found = 1'b0;
    drn_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (occ[i] && sqd[i]) begin
        drn_found = 1'b1;
        drn_idx   = IDX_W'(i);
      end
    end
  end

  logic do_disp;
  assign do_disp = disp_valid && alloc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      sqd    <= '0;
      hold   <= '0;
      r0     <= '0;
      r1     <= '0;
      sb     <= '0;
      free_q <= CNT_W'(ENTRIES);
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wb_valid && wb_in && t0[i] == wb_tag) r0[i] <= 1'b1;
        if (wb_valid && wb_in && t1[i] == wb_tag) r1[i] <= 1'b1;
        if (sq_valid && occ[i] && !sqd[i] && seq_q[i] > sq_seq &&
            !(iss_found && iss_idx == IDX_W'(i)))
          sqd[i] <= 1'b1;
        if (rel_valid && occ[i] && hold[i] && seq_q[i] == rel_seq)
          hold[i] <= 1'b0;
      end
      if (wb_valid && wb_in) sb[wb_tag] <= 1'b1;
      if (iss_found) occ[iss_idx] <= 1'b0;
      if (drn_found) begin
        occ[drn_idx] <= 1'b0;
        sqd[drn_idx] <= 1'b0;
      end
      if (do_disp) begin
        occ[alloc_idx]   <= 1'b1;
        sqd[alloc_idx]   <= 1'b0;
        hold[alloc_idx]  <= disp_nonspec;
        r0[alloc_idx]    <= s0_ok;
        r1[alloc_idx]    <= s1_ok;
        t0[alloc_idx]    <= disp_src0;
        t1[alloc_idx]    <= disp_src1;
        seq_q[alloc_idx] <= disp_seq;
        cls_q[alloc_idx] <= disp_cls;
        if (dst_in) sb[disp_dst] <= 1'b0;
      end
      free_q <= free_q + CNT_W'(iss_found) + CNT_W'(drn_found) - CNT_W'(do_disp);
    end
  end

  assign iss_valid = iss_found;
  assign iss_class = cls_q[iss_idx];
  assign iss_seq   = seq_q[iss_idx];
  assign drn_valid = drn_found;
  assign drn_seq   = seq_q[drn_idx];
  assign free_cnt  = free_q;
  assign full      = (free_q == '0);
endmodule

// File: rtl/iq_wakeup_chk.sv
module iq_wakeup_chk #(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 16,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic               disp_nonspec,
  input logic               disp_src0_rdy,
  input logic               disp_src1_rdy,
  input logic               sq_valid,
  input logic [SEQ_W-1:0]   sq_seq,
  input logic               iss_valid,
  input logic [SEQ_W-1:0]   iss_seq,
  input logic [CNT_W-1:0]   free_cnt,
  input logic [ENTRIES-1:0] occ,
  input logic [ENTRIES-1:0] hold,
  input logic [IDX_W-1:0]   iss_idx
);
  a_r10_free_matches: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt == CNT_W'(ENTRIES - $countones(occ)));

  a_r7_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !disp_valid) |=> free_cnt > $past(free_cnt));

  a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !hold[iss_idx]);

  a_r8_no_young_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !disp_valid) |=> !(iss_valid && iss_seq > $past(sq_seq)));

  a_r3_ready_dispatch_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && free_cnt == CNT_W'(ENTRIES) && disp_src0_rdy && disp_src1_rdy &&
     !disp_nonspec) |=> iss_valid);
endmodule

bind iq_wakeup iq_wakeup_chk #(
  .ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_nonspec(disp_nonspec),
  .disp_src0_rdy(disp_src0_rdy), .disp_src1_rdy(disp_src1_rdy),
  .sq_valid(sq_valid), .sq_seq(sq_seq), .iss_valid(iss_valid), .iss_seq(iss_seq),
  .free_cnt(free_cnt), .occ(occ), .hold(hold), .iss_idx(iss_idx)
);

// File: tb/iq_wakeup_tb_top.sv
module iq_wakeup_tb_top;
  localparam int ENTRIES = 8;
  localparam int TAG_W = 6;
  localparam int SEQ_W = 16;
  localparam int CNT_W = 4;
  localparam int NREGS = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic disp_valid, disp_nonspec, disp_src0_rdy, disp_src1_rdy;
  logic [SEQ_W-1:0] disp_seq, sq_seq, rel_seq;
  logic [3:0] disp_kind;
  logic [TAG_W-1:0] disp_src0, disp_src1, disp_dst, wb_tag;
  logic wb_valid, sq_valid, rel_valid;
  logic iss_valid, drn_valid, full;
  logic [2:0] iss_class;
  logic [SEQ_W-1:0] iss_seq, drn_seq;
  logic [CNT_W-1:0] free_cnt;

  iq_wakeup dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_seq(disp_seq),
    .disp_kind(disp_kind), .disp_nonspec(disp_nonspec), .disp_src0(disp_src0),
    .disp_src0_rdy(disp_src0_rdy), .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
    .disp_dst(disp_dst), .wb_valid(wb_valid), .wb_tag(wb_tag), .sq_valid(sq_valid),
    .sq_seq(sq_seq), .rel_valid(rel_valid), .rel_seq(rel_seq), .iss_valid(iss_valid),
    .iss_class(iss_class), .iss_seq(iss_seq), .drn_valid(drn_valid), .drn_seq(drn_seq),
    .free_cnt(free_cnt), .full(full)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    disp_valid = 0; disp_nonspec = 0; disp_kind = 4'b0010;
    disp_src0 = 6'd40; disp_src0_rdy = 1; disp_src1 = 6'd41; disp_src1_rdy = 1;
    disp_dst = 6'd42; disp_seq = '0;
    wb_valid = 0; wb_tag = '0; sq_valid = 0; sq_seq = '0; rel_valid = 0; rel_seq = '0;
  endtask

  task automatic setd(int seq, int kind, bit ns, int s0, bit r0, int dst);
    disp_valid = 1; disp_seq = SEQ_W'(seq); disp_kind = 4'(kind); disp_nonspec = ns;
    disp_src0 = TAG_W'(s0); disp_src0_rdy = r0; disp_src1 = 6'd41; disp_src1_rdy = 1;
    disp_dst = TAG_W'(dst);
  endtask

  task automatic disp(int seq, int kind, bit ns, int s0, bit r0, int dst);
    setd(seq, kind, ns, s0, r0, dst);
    cyc();
    idle();
  endtask

  task automatic wake(int tag);
    wb_valid = 1; wb_tag = TAG_W'(tag);
    cyc();
    idle();
  endtask

  function automatic int exp_class(int k);
    if (k[3]) return 0;
    if (k[2]) return 1;
    if (k[1]) return 2;
    if (k[0]) return 3;
    return 4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mask;
    idle();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 free", int'(free_cnt), ENTRIES);
    chk("R1 full", int'(full), 0);
    chk("R1 iss", int'(iss_valid), 0);
    chk("R1 drn", int'(drn_valid), 0);
    disp(10, 2, 0, 3, 0, NREGS + 8);
    chk("R1 sb clear", int'(iss_valid), 0);
    cyc();
    chk("R1 still waiting", int'(iss_valid), 0);
    wake(3);
    chk("R4 woken", int'(iss_valid), 1);
    chk("R4 seq", int'(iss_seq), 10);
    cyc();
    chk("R7 freed", int'(free_cnt), ENTRIES);

    for (int k = 0; k < 16; k++) begin
      disp(100 + k, k, 0, 40, 1, NREGS + 10);
      chk("R6 valid", int'(iss_valid), 1);
      chk("R6 class", int'(iss_class), exp_class(k));
      cyc();
    end

    disp(200, 2, 0, 5, 0, NREGS + 10);
    chk("R3 waits", int'(iss_valid), 0);
    wake(5);
    chk("R4 wake seq", int'(iss_seq), 200);
    chk("R4 wake valid", int'(iss_valid), 1);
    cyc();
    disp(201, 2, 0, 5, 0, NREGS + 10);
    chk("R3 scoreboard catch", int'(iss_valid), 1);
    chk("R3 scoreboard seq", int'(iss_seq), 201);
    cyc();
    disp(202, 2, 0, 40, 1, 5);
    cyc();
    disp(203, 2, 0, 5, 0, NREGS + 10);
    chk("R2 dst cleared", int'(iss_valid), 0);
    wake(5);
    chk("R2 rewake", int'(iss_seq), 203);
    cyc();

    setd(210, 2, 0, 7, 0, NREGS + 10);
    wb_valid = 1; wb_tag = 6'd7;
    cyc();
    idle();
    chk("R3 same-cycle", int'(iss_valid), 1);
    chk("R3 same-cycle seq", int'(iss_seq), 210);
    cyc();

    disp(220, 2, 0, 45, 0, NREGS + 10);
    chk("R5 src out of range", int'(iss_valid), 1);
    cyc();
    disp(221, 2, 0, 40, 1, NREGS + 5);
    cyc();
    disp(222, 2, 0, 5, 0, NREGS + 10);
    chk("R5 dst alias", int'(iss_valid), 1);
    chk("R5 dst alias seq", int'(iss_seq), 222);
    cyc();

    disp(305, 2, 0, 9, 0, NREGS + 10);
    disp(301, 2, 0, 9, 0, NREGS + 10);
    disp(307, 2, 0, 9, 0, NREGS + 10);
    disp(303, 2, 0, 9, 0, NREGS + 10);
    chk("R7 none before wake", int'(iss_valid), 0);
    wake(9);
    for (int j = 0; j < 4; j++) begin
      chk("R7 order valid", int'(iss_valid), 1);
      chk("R7 order seq", int'(iss_seq), 301 + 2 * j);
      cyc();
    end
    chk("R7 empty", int'(free_cnt), ENTRIES);

    for (int j = 0; j < 4; j++) disp(400 + j, 2, 0, 11, 0, NREGS + 10);
    sq_valid = 1; sq_seq = 16'd401;
    cyc();
    idle();
    mask = 0;
    for (int j = 0; j < 2; j++) begin
      chk("R8 drain valid", int'(drn_valid), 1);
      if (drn_seq >= 16'd400 && drn_seq <= 16'd403) mask |= 1 << int'(drn_seq - 16'd400);
      cyc();
    end
    chk("R8 drained set", mask, 12);
    chk("R8 drain done", int'(drn_valid), 0);
    chk("R8 free after drain", int'(free_cnt), ENTRIES - 2);
    wake(11);
    chk("R8 survivor 0", int'(iss_seq), 400);
    cyc();
    chk("R8 survivor 1", int'(iss_seq), 401);
    cyc();
    chk("R8 all gone", int'(iss_valid), 0);

    disp(500, 2, 1, 40, 1, NREGS + 10);
    chk("R9 held", int'(iss_valid), 0);
    cyc();
    chk("R9 held later", int'(iss_valid), 0);
    rel_valid = 1; rel_seq = 16'd501;
    cyc();
    idle();
    chk("R9 wrong release", int'(iss_valid), 0);
    rel_valid = 1; rel_seq = 16'd500;
    cyc();
    idle();
    chk("R9 released", int'(iss_valid), 1);
    chk("R9 released seq", int'(iss_seq), 500);
    cyc();

    for (int j = 0; j < ENTRIES; j++) begin
      disp(600 + j, 2, 0, 13, 0, NREGS + 10);
      chk("R10 free count", int'(free_cnt), ENTRIES - 1 - j);
    end
    chk("R10 full", int'(full), 1);
    disp(650, 2, 0, 40, 1, NREGS + 10);
    chk("R10 ignored free", int'(free_cnt), 0);
    chk("R10 ignored iss", int'(iss_valid), 0);
    wake(13);
    for (int j = 0; j < ENTRIES; j++) begin
      chk("R10 drain order", int'(iss_seq), 600 + j);
      cyc();
    end
    chk("R10 empty", int'(free_cnt), ENTRIES);
    chk("R10 no extra", int'(iss_valid), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule